// File: doc/BRIEF.md
# Four-Channel Prioritised Memory Copy Engine

The engine copies blocks of 16-bit or 32-bit units from a source address to a destination address on a simple memory-mapped bus. It has four channels. Each channel holds a source register, a destination register, a count register and a control register. Each unit is moved as a single bus read followed by a single bus write. A channel starts in one of two ways. In immediate mode it starts when it is enabled. In a blanking mode it starts on a vertical or horizontal blanking pulse. When two or more channels are ready, the lowest-numbered one is served. The choice is made again after every unit, so a more urgent channel can step in between two units of a longer block.

Software writes the registers through a one-word configuration port. A channel loads its working addresses, and in immediate mode its unit count, only in the write that turns its enable bit from 0 to 1. When a block finishes, the channel can raise a one-cycle interrupt. It can also re-arm itself for the next blanking pulse. An external hold input stops new units from starting. A CPU-stall output tells the processor when the engine is using the bus, or is about to.

Top module: `dma4_engine`

## Requirements
- R1: After reset, `bus_req`, `cpu_stall` and every bit of `irq` are 0.
- R2: Source and destination writes keep address bits 27:1 and force bit 0 to 0. A destination value below `DST_BASE` is dropped, and the old destination is kept.
- R3: A count value of 0 is stored as 0x200000 units. The 16-bit narrow variant instead stores 0x4000 units on channels 0 to 2 and 0x10000 units on channel 3.
- R4: Each 2-bit step field has four codes: 0 = increment, 1 = decrement, 2 = fixed, 3 = increment-with-reload. A step moves the address by one unit size (2 or 4 bytes). The source step field is control bits 3:2 and the destination step field is bits 5:4.
- R5: Control bit 1 selects the unit size, 1 for 32-bit and 0 for 16-bit, and drives `bus_word`. On the first unit of a block, both addresses are rounded down to unit alignment. A 16-bit write puts the low half of the read data on `bus_wdata` and zeros in the upper half.
- R6: Control bit 0 is the enable bit. A control write loads the working addresses (and, in immediate mode, the count) only when it changes the enable bit from 0 to 1. Rewriting the control register while the channel is enabled does not restart the block.
- R7: In immediate mode (trigger field bits 7:6 = 0), `bus_req` rises just after the third rising clock edge that follows the edge capturing the enabling write.
- R8: A pulse on `vblank_pulse` (trigger 1) or `hblank_pulse` (trigger 2) arms an enabled channel only if its mode matches and it has no block in progress. Its first unit then starts with the same three-edge latency as R7.
- R9: When a block completes, the enable bit is cleared unless repeat (bit 8) is set and the trigger is a blanking mode. `irq[ch]` pulses for one cycle if bit 9 is set.
- R10: With destination step 3, the working destination is reloaded from the destination register when a block completes. Between blocks the source keeps advancing.
- R11: Among the ready channels, the lowest-numbered channel starts the next unit. Pre-emption happens only between units. A pre-empted channel resumes from its saved working addresses and count.
- R12: While `ext_hold` is high, no new unit starts, and `cpu_stall` is high only while a unit is in flight. Otherwise `cpu_stall` is high while a unit is in flight or a channel is ready.
- R13: Each unit is a read phase followed by a write phase. Each phase holds its request, address and direction until `bus_ready` is seen. The write data equals the data read in that unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Register write value |
| vblank_pulse | input | 1 | Vertical blanking trigger |
| hblank_pulse | input | 1 | Horizontal blanking trigger |
| ext_hold | input | 1 | External agent blocks new units |
| bus_req | output | 1 | Bus phase active |
| bus_we | output | 1 | 1 = write phase, 0 = read phase |
| bus_word | output | 1 | 1 = 32-bit unit, 0 = 16-bit unit |
| bus_addr | output | 28 | Byte address of the phase |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Phase accepted |
| irq | output | 4 | Per-channel completion pulse |
| cpu_stall | output | 1 | Processor must wait |

## Verification
Two functions can land in the same cycle: a lower-numbered channel becoming ready, and the arbitration point of a higher-numbered channel that is in the middle of a block. The bench arms channel 2 for four units. After its first unit has completed, it arms channel 0. The three-cycle start latency then makes channel 0 ready while channel 2 is still moving units. The trace passes if channel 0's reads are contiguous, channel 2's reads stay in address order, and channel 2 finishes after channel 0. A second case holds the bus with `ext_hold` while channels 1 and 3 arm together. After release, channel 1 must go first.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [1:0] {
        STEP_INC = 2'd0,
        STEP_DEC = 2'd1,
        STEP_FIX = 2'd2,
        STEP_RLD = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        TRIG_NOW = 2'd0,
        TRIG_VBL = 2'd1,
        TRIG_HBL = 2'd2,
        TRIG_RSV = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_CNT = 2'd2,
        SEL_CTL = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RD   = 2'd1,
        ENG_WR   = 2'd2
    } eng_e;

    // control word, bit 0 is the enable bit (first member is the MSB)
    typedef struct packed {
        logic  irq_en;    // bit 9
        logic  rpt;       // bit 8
        trig_e trig;      // bits 7:6
        step_e dst_step;  // bits 5:4
        step_e src_step;  // bits 3:2
        logic  unit32;    // bit 1
        logic  en;        // bit 0
    } ctrl_t;

endpackage

// File: rtl/dma4_arb.sv
module dma4_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          vld
);
    // lowest index wins: scan downwards so the last hit is the lowest
    always_comb begin
        idx = '0;
        vld = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
                vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int ADDR_W      = 28,
    parameter int CNT_FIELD_W = 21,
    parameter int CW          = 22,
    parameter int ZERO_CNT    = 32'h200000,
    parameter logic [ADDR_W-1:0] DST_BASE = '0,
    parameter int START_LAT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              vblank,
    input  logic              hblank,
    input  logic              unit_done,
    output logic              ready,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic              unit32,
    output logic              irq
);
    localparam int DW = $clog2(START_LAT + 1);
    localparam int CBITS = $bits(ctrl_t);

    typedef struct packed {
        logic [ADDR_W-1:0] src, dst, wsrc, wdst;
        logic [CW-1:0]     cnt, wcnt;
        ctrl_t             ctl;
        logic              busy, first, irq;
        logic [DW-1:0]     dly;
    } ch_st_t;

    ch_st_t s_q, s_d;

    logic unused_hi;
    assign unused_hi = ^wr_data[31:ADDR_W];

    function automatic logic [ADDR_W-1:0] adv(input logic [ADDR_W-1:0] a,
                                              input step_e m, input logic w32);
        logic [ADDR_W-1:0] sz;
        sz = w32 ? ADDR_W'(4) : ADDR_W'(2);
        case (m)
            STEP_DEC: adv = a - sz;
            STEP_FIX: adv = a;
            default:  adv = a + sz;
        endcase
    endfunction

    logic [ADDR_W-1:0] amask, wval;
    logic [CNT_FIELD_W-1:0] cfield;
    ctrl_t nc;
    logic blank_hit;

    assign amask   = s_q.ctl.unit32 ? ~ADDR_W'(3) : ~ADDR_W'(1);
    assign cur_src = s_q.first ? (s_q.wsrc & amask) : s_q.wsrc;
    assign cur_dst = s_q.first ? (s_q.wdst & amask) : s_q.wdst;
    assign unit32  = s_q.ctl.unit32;
    assign ready   = s_q.ctl.en && s_q.busy && (s_q.dly == '0);
    assign irq     = s_q.irq;
    assign wval    = wr_data[ADDR_W-1:0] & ~ADDR_W'(1);
    assign cfield  = wr_data[CNT_FIELD_W-1:0];
    assign nc      = ctrl_t'(wr_data[CBITS-1:0]);
    assign blank_hit = s_q.ctl.en && !s_q.busy &&
                       ((vblank && s_q.ctl.trig == TRIG_VBL) ||
                        (hblank && s_q.ctl.trig == TRIG_HBL));

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (s_q.dly != '0) s_d.dly = s_q.dly - DW'(1);

        if (unit_done) begin
            s_d.wsrc  = adv(cur_src, s_q.ctl.src_step, s_q.ctl.unit32);
            s_d.wdst  = adv(cur_dst, s_q.ctl.dst_step, s_q.ctl.unit32);
            s_d.wcnt  = s_q.wcnt - CW'(1);
            s_d.first = 1'b0;
            if (s_q.wcnt == CW'(1)) begin
                s_d.busy = 1'b0;
                if (!s_q.ctl.rpt || s_q.ctl.trig == TRIG_NOW) s_d.ctl.en = 1'b0;
                if (s_q.ctl.dst_step == STEP_RLD) s_d.wdst = s_q.dst;
                s_d.irq = s_q.ctl.irq_en;
            end
        end

        if (blank_hit) begin
            s_d.wcnt  = s_q.cnt;
            s_d.busy  = 1'b1;
            s_d.first = 1'b1;
            s_d.dly   = DW'(START_LAT - 1);
        end

        if (wr_en) begin
            case (sel_e'(wr_sel))
                SEL_SRC: s_d.src = wval;
                SEL_DST: if (wval >= DST_BASE) s_d.dst = wval;
                SEL_CNT: s_d.cnt = (cfield == '0) ? CW'(ZERO_CNT) : CW'(cfield);
                default: begin
                    s_d.ctl = nc;
                    if (!s_q.ctl.en && nc.en) begin
                        s_d.wsrc  = s_q.src;
                        s_d.wdst  = s_q.dst;
                        s_d.first = 1'b1;
                        s_d.busy  = 1'b0;
                        if (nc.trig == TRIG_NOW) begin
                            s_d.wcnt = s_q.cnt;
                            s_d.busy = 1'b1;
                            s_d.dly  = DW'(START_LAT - 1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9
    last_unit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && s_q.wcnt == CW'(1) && !wr_en) |=> !s_q.busy);
    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R11
    done_when_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done |-> s_q.busy);
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int ADDR_W    = 28,
    parameter bit NARROW    = 1'b0,
    parameter logic [ADDR_W-1:0] DST_BASE = 28'h2000000,
    parameter int START_LAT = 3,
    localparam int CHW      = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              vblank_pulse,
    input  logic              hblank_pulse,
    input  logic              ext_hold,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ready,
    output logic [NCH-1:0]    irq,
    output logic              cpu_stall
);
    localparam int CNT_FIELD_W = NARROW ? 16 : 21;
    localparam int CW          = CNT_FIELD_W + 1;

    typedef struct packed {
        eng_e              st;
        logic [CHW-1:0]    ch;
        logic [ADDR_W-1:0] sa, da;
        logic              w32;
        logic [31:0]       data;
    } eng_t;

    eng_t e_q, e_d;

    logic [NCH-1:0]    rdy, u32, done_vec;
    logic [ADDR_W-1:0] csrc [NCH];
    logic [ADDR_W-1:0] cdst [NCH];
    logic [CHW-1:0]    gidx;
    logic              gvld;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int ZC = NARROW ? ((i == NCH - 1) ? 32'h10000 : 32'h4000) : 32'h200000;
        dma4_chan #(
            .ADDR_W(ADDR_W), .CNT_FIELD_W(CNT_FIELD_W), .CW(CW),
            .ZERO_CNT(ZC), .DST_BASE(DST_BASE), .START_LAT(START_LAT)
        ) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_en(cfg_we && cfg_ch == CHW'(i)),
            .wr_sel(cfg_sel), .wr_data(cfg_wdata),
            .vblank(vblank_pulse), .hblank(hblank_pulse),
            .unit_done(done_vec[i]),
            .ready(rdy[i]), .cur_src(csrc[i]), .cur_dst(cdst[i]),
            .unit32(u32[i]), .irq(irq[i])
        );
    end

    dma4_arb #(.N(NCH), .IW(CHW)) u_arb (.req(rdy), .idx(gidx), .vld(gvld));

    always_comb begin
        e_d      = e_q;
        done_vec = '0;
        case (e_q.st)
            ENG_IDLE: if (gvld && !ext_hold) begin
                e_d.st  = ENG_RD;
                e_d.ch  = gidx;
                e_d.sa  = csrc[gidx];
                e_d.da  = cdst[gidx];
                e_d.w32 = u32[gidx];
            end
            ENG_RD: if (bus_ready) begin
                e_d.data = bus_rdata;
                e_d.st   = ENG_WR;
            end
            ENG_WR: if (bus_ready) begin
                e_d.st = ENG_IDLE;
                done_vec[e_q.ch] = 1'b1;
            end
            default: e_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign bus_req   = (e_q.st != ENG_IDLE);
    assign bus_we    = (e_q.st == ENG_WR);
    assign bus_word  = e_q.w32;
    assign bus_addr  = (e_q.st == ENG_WR) ? e_q.da : e_q.sa;
    assign bus_wdata = e_q.w32 ? e_q.data : {16'h0, e_q.data[15:0]};
    assign cpu_stall = bus_req || (|rdy && !ext_hold);

    // R13
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
    // R13
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we) |-> ($past(bus_req) && !$past(bus_we)));
    // R12
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hold && !bus_req) |=> !bus_req);
endmodule

// File: tb/sim_dma4_engine.sv
`timescale 1ns/1ps
module sim_dma4_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_ch = '0, cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic vblank_pulse = 1'b0, hblank_pulse = 1'b0, ext_hold = 1'b0;
    logic bus_req, bus_we, bus_word, bus_ready, cpu_stall;
    logic [27:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [3:0] irq;
    logic rdy_en = 1'b1;

    int checks = 0, fails = 0, n = 0;
    int irq_cnt [4];
    logic [27:0] la [256];
    logic        lw [256];
    logic        l32 [256];
    logic [31:0] ld [256];

    always #10 clk = ~clk;

    function automatic logic [31:0] mem(input logic [27:0] a);
        return 32'hC0DE0000 ^ {4'h0, a};
    endfunction

    assign bus_ready = bus_req & rdy_en;
    assign bus_rdata = mem(bus_addr);

    dma4_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .vblank_pulse(vblank_pulse), .hblank_pulse(hblank_pulse),
        .ext_hold(ext_hold), .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq), .cpu_stall(cpu_stall)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (bus_req && bus_ready && n < 256) begin
                la[n] = bus_addr; lw[n] = bus_we; l32[n] = bus_word; ld[n] = bus_wdata;
                n = n + 1;
            end
            for (int i = 0; i < 4; i++) if (irq[i]) irq_cnt[i] = irq_cnt[i] + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch[1:0]; cfg_sel = sel[1:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
        wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, c);
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int k = 0; k < 5000 && quiet < 4; k++) begin
            @(negedge clk);
            quiet = (bus_req || cpu_stall) ? 0 : quiet + 1;
        end
    endtask

    task automatic wait_log(input int k);
        for (int t = 0; t < 5000 && n < k; t++) @(negedge clk);
    endtask

    task automatic clr();
        n = 0;
        for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
    endtask

    // check one read/write pair of a unit
    task automatic chk_unit(input int u, input logic [27:0] ra, input logic [27:0] wa,
                            input logic w32, input string tag);
        logic [31:0] ed;
        ed = w32 ? mem(ra) : {16'h0, mem(ra)[15:0]};
        chk(!lw[2*u] && la[2*u] == ra, {tag, " read addr"}, {4'h0, la[2*u]}, {4'h0, ra});
        chk(lw[2*u+1] && la[2*u+1] == wa, {tag, " write addr"}, {4'h0, la[2*u+1]}, {4'h0, wa});
        chk(ld[2*u+1] == ed && l32[2*u+1] == w32, {tag, " write data"}, ld[2*u+1], ed);
    endtask

    task automatic t_reset();
        chk(bus_req == 1'b0 && cpu_stall == 1'b0 && irq == 4'h0, "R1 reset outputs",
            {29'h0, bus_req, cpu_stall, |irq}, 32'h0);
    endtask

    task automatic t_immediate();
        clr();
        setup(1, 32'h0001000, 32'h2000100, 3);
        wr(1, 3, 32'h203);
        chk(!bus_req, "R7 no req after edge 0", {31'h0, bus_req}, 0);
        @(negedge clk); chk(!bus_req, "R7 no req after edge 1", {31'h0, bus_req}, 0);
        @(negedge clk); chk(!bus_req, "R7 no req after edge 2", {31'h0, bus_req}, 0);
        @(negedge clk); chk(bus_req, "R7 req after edge 3", {31'h0, bus_req}, 1);
        wait_idle();
        chk(n == 6, "R13 entries of 3 units", n, 6);
        for (int u = 0; u < 3; u++)
            chk_unit(u, 28'h0001000 + 28'(4*u), 28'h2000100 + 28'(4*u), 1'b1, "R4 inc");
        chk(irq_cnt[1] == 1, "R9 irq once", irq_cnt[1], 1);
        clr();
        wr(1, 3, 32'h203);
        wait_idle();
        chk(n == 6, "R9 enable cleared so rewrite rearms", n, 6);
    endtask

    task automatic t_steps();
        clr();
        setup(2, 32'hF0003001, 32'h2000200, 3);
        wr(2, 1, 32'h0000400);
        wr(2, 3, 32'h025);
        wait_idle();
        chk(n == 6, "R4 dec/fix entries", n, 6);
        for (int u = 0; u < 3; u++)
            chk_unit(u, 28'h0003000 - 28'(2*u), 28'h2000200, 1'b0, "R2 R4 R5 dec fixed half");
        clr();
        setup(0, 32'h0005006, 32'h2000012, 2);
        wr(0, 3, 32'h003);
        wait_idle();
        chk_unit(0, 28'h0005004, 28'h2000010, 1'b1, "R5 first aligned");
        chk_unit(1, 28'h0005008, 28'h2000014, 1'b1, "R5 second");
    endtask

    task automatic t_rearm();
        clr();
        setup(1, 32'h0006000, 32'h2000600, 6);
        wr(1, 3, 32'h003);
        wait_log(4);
        wr(1, 3, 32'h003);
        wait_idle();
        chk(n == 12, "R6 no restart entries", n, 12);
        chk(la[10] == 28'h0006014, "R6 last read addr", {4'h0, la[10]}, 32'h0006014);
    endtask

    task automatic t_zero();
        clr();
        setup(3, 32'h000A000, 32'h2000A00, 0);
        wr(3, 3, 32'h203);
        wait_log(40);
        chk(n >= 40 && irq_cnt[3] == 0 && cpu_stall, "R3 zero count runs long", n, 40);
        wr(3, 3, 32'h000);
        wait_idle();
        chk(irq_cnt[3] == 0, "R3 no completion", irq_cnt[3], 0);
    endtask

    task automatic pulse(input bit v);
        @(negedge clk);
        if (v) vblank_pulse = 1'b1; else hblank_pulse = 1'b1;
        @(negedge clk);
        vblank_pulse = 1'b0; hblank_pulse = 1'b0;
    endtask

    task automatic t_blank();
        clr();
        setup(0, 32'h0007000, 32'h2000300, 2);
        wr(0, 3, 32'h373);
        repeat (10) @(negedge clk);
        chk(n == 0, "R8 no start on enable", n, 0);
        pulse(1'b0);
        repeat (10) @(negedge clk);
        chk(n == 0, "R8 wrong pulse ignored", n, 0);
        pulse(1'b1);
        @(negedge clk); @(negedge clk);
        chk(!bus_req, "R8 no req after edge 2", {31'h0, bus_req}, 0);
        @(negedge clk);
        chk(bus_req, "R8 req after edge 3", {31'h0, bus_req}, 1);
        wait_idle();
        chk_unit(0, 28'h0007000, 28'h2000300, 1'b1, "R8 block1 u0");
        chk_unit(1, 28'h0007004, 28'h2000304, 1'b1, "R8 block1 u1");
        chk(irq_cnt[0] == 1, "R9 irq block1", irq_cnt[0], 1);
        n = 0;
        pulse(1'b1);
        wait_idle();
        chk(n == 4, "R9 repeat keeps enable", n, 4);
        chk_unit(0, 28'h0007008, 28'h2000300, 1'b1, "R10 reload u0");
        chk_unit(1, 28'h000700C, 28'h2000304, 1'b1, "R10 reload u1");
        n = 0;
        rdy_en = 1'b0;
        pulse(1'b1);
        repeat (6) @(negedge clk);
        pulse(1'b1);
        rdy_en = 1'b1;
        wait_idle();
        chk(n == 4, "R8 pulse while busy ignored", n, 4);
        wr(0, 3, 32'h000);
    endtask

    task automatic t_prio();
        clr();
        ext_hold = 1'b1;
        setup(3, 32'h000B000, 32'h2000B00, 1);
        setup(1, 32'h000C000, 32'h2000C00, 1);
        wr(3, 3, 32'h003);
        wr(1, 3, 32'h003);
        repeat (8) @(negedge clk);
        chk(!bus_req && !cpu_stall, "R12 hold blocks and no stall", {30'h0, bus_req, cpu_stall}, 0);
        ext_hold = 1'b0;
        @(negedge clk);
        chk(cpu_stall, "R12 stall when ready", {31'h0, cpu_stall}, 1);
        wait_idle();
        chk(la[0] == 28'h000C000 && la[2] == 28'h000B000, "R11 lowest first",
            {4'h0, la[0]}, 32'h000C000);
        clr();
        setup(2, 32'h0008000, 32'h2000400, 4);
        setup(0, 32'h0009000, 32'h2000500, 2);
        wr(2, 3, 32'h003);
        wait_log(2);
        wr(0, 3, 32'h003);
        wait_idle();
        begin
            int p0 = -1, plast = -1, k2 = 0;
            logic ord = 1'b1;
            for (int i = 0; i < n; i += 2) begin
                if (la[i] == 28'h0009000) p0 = i;
                if (la[i][15:12] == 4'h8) begin
                    if (la[i] != 28'h0008000 + 28'(4*k2)) ord = 1'b0;
                    k2++;
                    plast = i;
                end
            end
            chk(n == 12, "R11 total entries", n, 12);
            chk(p0 >= 0 && la[p0+2] == 28'h0009004, "R11 ch0 contiguous", {4'h0, la[p0+2]}, 32'h0009004);
            chk(ord && k2 == 4, "R11 ch2 resumes in order", k2, 4);
            chk(p0 < plast, "R11 preempted between units", p0, plast);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_steps();
        t_rearm();
        t_zero();
        t_blank();
        t_prio();
        finish_run();
    end
endmodule